// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block watches the destination address at the head of each received frame and decides whether a group-addressed frame should be accepted. It folds the address bytes through an Ethernet CRC-32 register and keeps the six top bits of the result as a hash. That hash selects one bit of a 64-bit multicast table, and the table is loaded by software as eight byte-wide rows. The hash is also driven out so that receive software can jump straight to the matching bucket when it searches its group list.

Bytes arrive one per cycle when `in_valid` is high. `in_first` marks the first address byte and restarts the computation. A pulse on `hash_valid` reports each completed lookup, and `filt_pass` then says whether the frame hits the table. A table hit on a group address passes the frame, whatever the rest of the receive filtering would decide. Unicast matching and other filter modes live elsewhere.

Top module: `mcast_hash_filter`

## Requirements
- R1: After a synchronous reset, `hash_value` is 0, `hash_valid` is 0 and `filt_pass` is 0.
- R2: The CRC register starts at all ones. For each address byte, bit 0 is taken first. For each bit, the feedback is register bit 31 XOR the data bit. The register shifts left by one and is XORed with 0x04C11DB7 when the feedback is 1. After the sixth byte, `hash_value` equals register bits 31:26, with no final inversion, and register bit 31 goes to `hash_value` bit 5.
- R3: Let edge E be the clock edge that accepts the sixth address byte. `hash_valid` is high for exactly one cycle, starting at edge E+1. `hash_value` and `filt_pass` take their new values at that same edge.
- R4: A write with `tbl_we` high stores `tbl_wdata` into row `tbl_addr`. Hash bits 5:3 pick the row and hash bits 2:0 pick the bit within it, so hash h reads table bit 8*row+bit = h. For example, hash 000000 reads row 0 bit 0, 010000 reads row 2 bit 0, 100111 reads row 4 bit 7 and 111111 reads row 7 bit 7.
- R5: `filt_pass` is 1 exactly when the group bit is set and the table bit indexed by the hash is 1. The group bit is bit 0 of the first address byte.
- R6: When the group bit is clear, `filt_pass` is 0 even if every table bit is 1.
- R7: Once six bytes have been accepted, further bytes with `in_valid` high and `in_first` low are ignored until the next `in_first`. They cause no pulse on `hash_valid` and no change to the outputs. Bytes without `in_first` that arrive after reset, before any `in_first`, are also ignored.
- R8: An `in_first` byte that arrives in the middle of an address discards the partial address and starts a new one.
- R9: `hash_value` and `filt_pass` hold their values in every cycle in which `hash_valid` is low.
- R10: A lookup reads the table contents as they stand before edge E, so a row write on edge E itself affects only later lookups. Idle cycles between address bytes do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Address byte present this cycle |
| in_first | input | 1 | Byte is the first byte of a destination address |
| in_data | input | 8 | Address byte |
| tbl_we | input | 1 | Table row write enable |
| tbl_addr | input | 3 | Table row to write |
| tbl_wdata | input | 8 | Table row data |
| hash_value | output | 6 | Hash of the last completed address |
| hash_valid | output | 1 | One-cycle pulse: a new hash and pass decision are out |
| filt_pass | output | 1 | Last completed address passes the multicast filter |

## Verification
Take edge E as the edge that accepts the sixth byte. All three results are due one edge later, at E+1. `hash_valid` falls again at E+2, and in every other cycle the other two outputs must hold. The bench reference model keeps a one-entry pending result. It fills that entry at E, using the table as it stood before E. It moves the entry to its expected outputs at the following edge. The outputs are compared with the model on every falling edge, so a result that comes a cycle early or a cycle late is caught at once. Directed checks also read the pass decision several idle cycles after a frame. These include a one-hot table aimed at the computed hash, a neighbour bit that must miss, and a row write that lands on edge E.

// File: rtl/mchf_pkg.sv
package mchf_pkg;
  localparam int CRC_W = 32;
  typedef logic [CRC_W-1:0] crc_t;
  localparam crc_t CRC_PRESET = '1;
  localparam crc_t CRC32_POLY = 32'h04C1_1DB7;
endpackage

// File: rtl/mchf_crc_byte.sv
module mchf_crc_byte
  import mchf_pkg::*;
#(
  parameter crc_t POLY = CRC32_POLY,
  parameter int   DW   = 8
) (
  input  crc_t          crc_in,
  input  logic [DW-1:0] data_in,
  output crc_t          crc_out
);
  // one shift stage per data bit, bit 0 first
  logic [DW:0][CRC_W-1:0] chain;
  assign chain[0] = crc_in;

  for (genvar g = 0; g < DW; g++) begin : g_bit
    logic fb;
    assign fb = chain[g][CRC_W-1] ^ data_in[g];
    assign chain[g+1] = {chain[g][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign crc_out = chain[DW];
endmodule

// File: rtl/mchf_addr_seq.sv
module mchf_addr_seq
  import mchf_pkg::*;
#(
  parameter int   ADDR_BYTES = 6,
  parameter int   HASH_W     = 6,
  parameter crc_t POLY       = CRC32_POLY
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic [7:0]        in_data,
  output logic [HASH_W-1:0] hash_nx,
  output logic              done,
  output logic              grp
);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0] cnt_q;  // equals CNT_FULL when idle
  crc_t crc_q, crc_base, crc_nx;
  logic grp_q, take;

  assign take     = in_valid && (in_first || (cnt_q < CNT_FULL));
  assign crc_base = in_first ? CRC_PRESET : crc_q;

  mchf_crc_byte #(.POLY(POLY), .DW(8)) crc_i (
    .crc_in (crc_base),
    .data_in(in_data),
    .crc_out(crc_nx)
  );

  assign hash_nx = crc_nx[CRC_W-1 -: HASH_W];
  assign grp     = in_first ? in_data[0] : grp_q;
  assign done    = take && (in_first ? (ADDR_BYTES == 1) : (cnt_q == CNT_LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_FULL;
      crc_q <= CRC_PRESET;
      grp_q <= 1'b0;
    end else if (take) begin
      crc_q <= crc_nx;
      cnt_q <= in_first ? CNT_W'(1) : cnt_q + CNT_W'(1);
      if (in_first) grp_q <= in_data[0];
    end
  end

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_FULL);
endmodule

// File: rtl/mchf_mtable.sv
module mchf_mtable #(
  parameter int ROW_W     = 8,
  parameter int ROW_SEL_W = 3
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [ROW_SEL_W-1:0] waddr,
  input  logic [ROW_W-1:0]     wdata,
  input  logic [ROW_SEL_W-1:0] raddr,
  output logic [ROW_W-1:0]     rdata
);
  localparam int NROWS = 1 << ROW_SEL_W;

  logic [ROW_W-1:0] mem [NROWS];

  // registered read, old data on a same-edge write
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
  import mchf_pkg::*;
#(
  parameter int   ADDR_BYTES = 6,
  parameter int   HASH_W     = 6,
  parameter int   ROW_W      = 8,
  parameter crc_t POLY       = CRC32_POLY,
  localparam int  BIT_SEL_W  = $clog2(ROW_W),
  localparam int  ROW_SEL_W  = HASH_W - BIT_SEL_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_first,
  input  logic [7:0]           in_data,
  input  logic                 tbl_we,
  input  logic [ROW_SEL_W-1:0] tbl_addr,
  input  logic [ROW_W-1:0]     tbl_wdata,
  output logic [HASH_W-1:0]    hash_value,
  output logic                 hash_valid,
  output logic                 filt_pass
);
  logic [HASH_W-1:0] hash_nx, s1_hash;
  logic              done, grp, s1_v, s1_grp;
  logic [ROW_W-1:0]  row_q;

  mchf_addr_seq #(.ADDR_BYTES(ADDR_BYTES), .HASH_W(HASH_W), .POLY(POLY)) seq_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
    .in_data(in_data), .hash_nx(hash_nx), .done(done), .grp(grp)
  );

  mchf_mtable #(.ROW_W(ROW_W), .ROW_SEL_W(ROW_SEL_W)) tbl_i (
    .clk(clk), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_wdata),
    .raddr(hash_nx[HASH_W-1 -: ROW_SEL_W]), .rdata(row_q)
  );

  // stage 1: capture hash while the table row is read
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s1_hash <= '0;
      s1_grp  <= 1'b0;
    end else begin
      s1_v <= done;
      if (done) begin
        s1_hash <= hash_nx;
        s1_grp  <= grp;
      end
    end
  end

  // stage 2: bit select and registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      hash_valid <= 1'b0;
      hash_value <= '0;
      filt_pass  <= 1'b0;
    end else begin
      hash_valid <= s1_v;
      if (s1_v) begin
        hash_value <= s1_hash;
        filt_pass  <= s1_grp & row_q[s1_hash[BIT_SEL_W-1:0]];
      end
    end
  end

  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    hash_valid |=> !hash_valid);

  assert_valid_after_done_R3: assert property (@(posedge clk) disable iff (rst)
    hash_valid |-> $past(done, 2));

  assert_outputs_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !hash_valid |-> ($stable(hash_value) && $stable(filt_pass)));

  assert_pass_group_R6: assert property (@(posedge clk) disable iff (rst)
    (hash_valid && filt_pass) |-> $past(s1_grp));
endmodule

// File: tb/mcast_hash_filter_tb_top.sv
`timescale 1ns/1ps
module mcast_hash_filter_tb_top;
  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0, in_first = 0, tbl_we = 0;
  logic [7:0] in_data = 0, tbl_wdata = 0;
  logic [2:0] tbl_addr = 0;
  logic [5:0] hash_value;
  logic hash_valid, filt_pass;

  always #10 clk = ~clk;

  mcast_hash_filter dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
    .in_data(in_data), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .hash_value(hash_value),
    .hash_valid(hash_valid), .filt_pass(filt_pass)
  );

  int total = 0, bad = 0, pulses = 0;

  // ---------------- reference model ----------------
  bit [63:0] m_tbl = '0;
  bit [31:0] m_crc;
  int        m_cnt = 6;
  bit        m_grp, p1, p1_pass;
  bit [5:0]  p1_hash;
  bit [5:0]  e_hash = 0;
  bit        e_valid = 0, e_pass = 0;

  function automatic bit [31:0] step(bit [31:0] c, bit [7:0] d);
    for (int j = 0; j < 8; j++) begin
      bit f;
      f = c[31] ^ d[j];
      c = c << 1;
      if (f) c = c ^ 32'h04C11DB7;
    end
    return c;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 6; p1 = 0; e_hash = 0; e_valid = 0; e_pass = 0;
    end else begin
      bit acc;
      e_valid = p1;
      if (p1) begin e_hash = p1_hash; e_pass = p1_pass; end
      p1 = 0; acc = 0;
      if (in_valid && in_first) begin
        m_crc = step(32'hFFFFFFFF, in_data); m_cnt = 1; m_grp = in_data[0]; acc = 1;
      end else if (in_valid && m_cnt < 6) begin
        m_crc = step(m_crc, in_data); m_cnt++; acc = 1;
      end
      if (acc && m_cnt == 6) begin
        p1 = 1; p1_hash = m_crc[31:26]; p1_pass = m_grp & m_tbl[p1_hash];
      end
      if (tbl_we) m_tbl[tbl_addr*8 +: 8] = tbl_wdata;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (hash_valid) pulses++;
      total++;
      if (hash_valid !== e_valid) begin
        bad++; $display("FAIL R3 hash_valid actual=%0b expected=%0b", hash_valid, e_valid);
      end
      total++;
      if (hash_value !== e_hash) begin
        bad++; $display("FAIL R2/R9 hash_value actual=%0h expected=%0h", hash_value, e_hash);
      end
      total++;
      if (filt_pass !== e_pass) begin
        bad++; $display("FAIL R5/R9 filt_pass actual=%0b expected=%0b", filt_pass, e_pass);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  logic [7:0] fb [16];

  function automatic bit [5:0] ref_hash();
    bit [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < 6; i++) c = step(c, fb[i]);
    return c[31:26];
  endfunction

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wr_row(int a, int d);
    @(posedge clk); #1;
    tbl_we = 1; tbl_addr = 3'(a); tbl_wdata = 8'(d);
    @(posedge clk); #1;
    tbl_we = 0;
  endtask

  task automatic load_all(int d);
    for (int r = 0; r < 8; r++) wr_row(r, d);
  endtask

  // n bytes; gap inserts an idle cycle after each; wr_last writes a row with the last byte
  task automatic send(int n, bit gap, bit wr_last, int wa, int wd);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1; in_first = (i == 0); in_data = fb[i];
      if (wr_last && i == n - 1) begin
        tbl_we = 1; tbl_addr = 3'(wa); tbl_wdata = 8'(wd);
      end
      if (gap) begin
        @(posedge clk); #1;
        in_valid = 0; in_first = 0; tbl_we = 0;
      end
    end
    @(posedge clk); #1;
    in_valid = 0; in_first = 0; tbl_we = 0;
    idle(4);
  endtask

  task automatic set_addr(int a0, int a1, int a2, int a3, int a4, int a5);
    fb[0] = 8'(a0); fb[1] = 8'(a1); fb[2] = 8'(a2);
    fb[3] = 8'(a3); fb[4] = 8'(a4); fb[5] = 8'(a5);
  endtask

  task automatic chk(string req, int act, int exp);
    @(negedge clk);
    total++;
    if (act !== exp) begin
      bad++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit [5:0] h;
    int p0;
    idle(4);
    #1 rst = 0;
    // R1 reset state
    @(negedge clk);
    total++;
    if (hash_value !== 0 || hash_valid !== 0 || filt_pass !== 0) begin
      bad++; $display("FAIL R1 actual=%0h/%0b/%0b expected=0/0/0", hash_value, hash_valid, filt_pass);
    end
    // R7 stray bytes before any first byte
    fb[0] = 8'h33;
    for (int i = 0; i < 7; i++) begin
      @(posedge clk); #1; in_valid = 1; in_first = 0; in_data = 8'(i);
    end
    @(posedge clk); #1; in_valid = 0;
    idle(3);
    chk("R7 no pulse before first byte", pulses, 0);

    load_all(8'hFF);
    // R2 R5 multicast hits full table
    set_addr(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01);
    send(6, 0, 0, 0, 0);
    chk("R5 full table group hit", filt_pass, 1);
    chk("R2 hash value", hash_value, ref_hash());
    // R6 unicast with full table
    set_addr(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
    send(6, 0, 0, 0, 0);
    chk("R6 group clear", filt_pass, 0);
    // R4 one-hot aimed at hash
    set_addr(8'h33, 8'h33, 8'h00, 8'h00, 8'h00, 8'h16);
    h = ref_hash();
    load_all(0);
    wr_row(h[5:3], 1 << h[2:0]);
    send(6, 1, 0, 0, 0);  // R10 idle gaps between bytes
    chk("R4 one-hot hit", filt_pass, 1);
    wr_row(h[5:3], (1 << h[2:0]) ^ 8'hFF);
    send(6, 0, 0, 0, 0);
    chk("R4 neighbour bits miss", filt_pass, 0);
    // R7 extra bytes after sixth
    wr_row(h[5:3], 8'hFF);
    for (int i = 6; i < 12; i++) fb[i] = 8'(i * 37);
    p0 = pulses;
    send(12, 0, 0, 0, 0);
    chk("R7 single pulse per address", pulses - p0, 1);
    chk("R7 hash unaffected by tail", hash_value, h);
    // R8 restart mid-address
    set_addr(8'h01, 8'hAA, 8'hBB, 8'h00, 8'h00, 8'h00);
    send(3, 0, 0, 0, 0);
    set_addr(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    p0 = pulses;
    send(6, 0, 0, 0, 0);
    chk("R8 restart hash", hash_value, ref_hash());
    chk("R8 restart pulse count", pulses - p0, 1);
    // R10 write on edge E does not affect this lookup
    set_addr(8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h0E);
    h = ref_hash();
    load_all(0);
    send(6, 0, 1, h[5:3], 8'hFF);
    chk("R10 same-edge write unseen", filt_pass, 0);
    send(6, 0, 0, 0, 0);
    chk("R10 write seen later", filt_pass, 1);
    // a few varied addresses against the model
    for (int k = 0; k < 20; k++) begin
      set_addr(k * 13 + 1, k * 7, 255 - k, k * 29, k, k * 3 + 5);
      if (k % 4 == 0) wr_row(k % 8, k * 41);
      send(6, k % 3 == 0, 0, 0, 0);
    end
    idle(4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule